// File: doc/BRIEF.md
# Pixel-Rate PHY Configuration Sequencer

This block turns a requested pixel clock rate into the register programming of a video transmitter PHY. A request carries the rate in hertz and two sync-polarity flags. The block places the rate in one of four bands and programs the PLL registers from that band's recommended settings. It then waits for the PLL to lock, reads back the PLL band code that the PHY reports, trims it and writes it back. After a final settling wait it programs the three output-drive registers. A rate of zero does not run this sequence. It drops the PHY into a low-power state with two register writes.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle. A requester holds `req_valid` and the request fields steady until a rising clock edge sees both high. Requests offered while the block is busy are not taken and leave no trace. Waits are counted in clock cycles through parameters, so an integration can size them for its clock. `done` pulses for one cycle after the last register write.

Top module: `phy_rate_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Requests offered while busy have no effect on any output. `done` is high for exactly one cycle, and `req_ready` returns in the following cycle.
- R2: A rate of zero sets `ana_cfg1` to 0x00000007 and `pll_cfg1` to 0 one cycle after acceptance. No other configuration register changes. `done` is high in the cycle after those writes.
- R3: The band is the count of thresholds that the rate strictly exceeds: 27,000,000, 74,250,000 and 148,500,000 Hz. This gives bands 0 to 3.
- R4: One cycle after acceptance of a nonzero rate, `pll_cfg1` takes the band's table value with bit 26 cleared. `pll_cfg2` takes the band's table value with bits [3:0] replaced by `prediv_cur` as sampled at acceptance.
- R5: After W15_CYC further cycles, `pll_cfg3` becomes 0x00000001 and bit 25 of `pll_cfg1` is set. Both writes happen on the same edge.
- R6: After W100_CYC further cycles, the code `phy_status[16:11]` is increased by 2 in band 3 (0 in other bands) and saturated at 63. On the same edge, `pll_cfg1` bits 31 and 30 are set and the result is ORed into bits [5:0].
- R7: After another W100_CYC cycles, `ana_cfg1`, `ana_cfg2` and `ana_cfg3` take the band's table values. In bands 0 and 1, `cal_code >> 2` is ORed into `ana_cfg2`. `done` is high in the next cycle.
- R8: On acceptance of any request, `dbg_ctrl[15:8]` becomes 2 if `req_hsync_low` is set, plus 1 if `req_vsync_low` is set. All other `dbg_ctrl` bits are zero.
- R9: The table holds, per band, values in the order pll1 / pll2 / ana1 / ana2 / ana3. Band 0: 3ddc5040 / 8008430a / 11ffff7f / 80623000 / 0f80c285. Band 1: 3ddc5040 / 80084343 / 11ffff7f / 80623000 / 0f814385. Band 2: 3ddc5040 / 80084381 / 01ffff7f / 8063a800 / 0f81c485. Band 3: 35dc5fc0 / 800863c0 / 01ffff7f / 8063b000 / 0f8246b5.
- R10: While `rst_n` is low, every configuration output is zero, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_rate | input | 32 | Requested pixel rate in Hz, 0 for low power |
| req_hsync_low | input | 1 | Horizontal sync is active low |
| req_vsync_low | input | 1 | Vertical sync is active low |
| prediv_cur | input | 4 | Current PLL predivider setting to preserve |
| cal_code | input | 6 | Latched termination calibration code |
| phy_status | input | 32 | PHY status word, PLL band code in [16:11] |
| dbg_ctrl | output | 32 | Sync polarity control register |
| pll_cfg1 | output | 32 | PLL configuration register 1 |
| pll_cfg2 | output | 32 | PLL configuration register 2 |
| pll_cfg3 | output | 32 | PLL configuration register 3 |
| ana_cfg1 | output | 32 | Output-drive configuration register 1 |
| ana_cfg2 | output | 32 | Output-drive configuration register 2 |
| ana_cfg3 | output | 32 | Output-drive configuration register 3 |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
A wrong band or table entry shows in `pll_cfg1` and `pll_cfg2` one cycle after acceptance. A wrong calibration or output-drive value shows only at the final write, and by then the PLL registers may look correct. A miscounted wait moves the bit-25 write, the band-code write or the final write by whole cycles. A stuck or skipped state shows as `done` or `req_ready` at the wrong cycle. Because outputs are compared with a reference on every cycle, each of these faults is caught at the edge where it first appears. A busy-time request that is wrongly taken shows as a change in `dbg_ctrl` or the PLL registers in the middle of a sequence.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
  localparam int unsigned RATE_W = 32;
  localparam int unsigned NUM_THR = 3;
  localparam int unsigned BAND_W = 2;
  localparam int unsigned CODE_W = 6;
  localparam logic [RATE_W-1:0] RATE_THR [NUM_THR] = '{32'd27_000_000, 32'd74_250_000, 32'd148_500_000};
  localparam logic [31:0] PLL3_VAL = 32'h0000_0001;
  localparam logic [31:0] LOWPWR_ANA1 = 32'h0000_0007;

  typedef struct packed {
    logic [31:0] pll1;
    logic [31:0] pll2;
    logic [31:0] ana1;
    logic [31:0] ana2;
    logic [31:0] ana3;
    logic        use_cal;
    logic [1:0]  code_boost;
  } band_set_t;
endpackage

// File: rtl/rate_band_sel.sv
module rate_band_sel
  import phycfg_pkg::*;
(
  input  logic [RATE_W-1:0] rate,
  output logic [BAND_W-1:0] band
);
  logic [NUM_THR-1:0] above;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign above[t] = rate > RATE_THR[t];
  end

  always_comb begin
    band = '0;
    for (int t = 0; t < NUM_THR; t++) band = band + BAND_W'(above[t]);
  end
endmodule

// File: rtl/band_table.sv
module band_table
  import phycfg_pkg::*;
(
  input  logic [BAND_W-1:0] band,
  output band_set_t         set
);
  always_comb begin
    unique case (band)
      2'd0: set = '{32'h3ddc5040, 32'h8008430a, 32'h11ffff7f, 32'h80623000, 32'h0f80c285, 1'b1, 2'd0};
      2'd1: set = '{32'h3ddc5040, 32'h80084343, 32'h11ffff7f, 32'h80623000, 32'h0f814385, 1'b1, 2'd0};
      2'd2: set = '{32'h3ddc5040, 32'h80084381, 32'h01ffff7f, 32'h8063a800, 32'h0f81c485, 1'b0, 2'd0};
      default: set = '{32'h35dc5fc0, 32'h800863c0, 32'h01ffff7f, 32'h8063b000, 32'h0f8246b5, 1'b0, 2'd2};
    endcase
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/phy_rate_seq.sv
module phy_rate_seq
  import phycfg_pkg::*;
#(
  parameter int unsigned W15_CYC  = 1_875_000,
  parameter int unsigned W100_CYC = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_rate,
  input  logic        req_hsync_low,
  input  logic        req_vsync_low,
  input  logic [3:0]  prediv_cur,
  input  logic [5:0]  cal_code,
  input  logic [31:0] phy_status,
  output logic [31:0] dbg_ctrl,
  output logic [31:0] pll_cfg1,
  output logic [31:0] pll_cfg2,
  output logic [31:0] pll_cfg3,
  output logic [31:0] ana_cfg1,
  output logic [31:0] ana_cfg2,
  output logic [31:0] ana_cfg3,
  output logic        done
);
  localparam int unsigned WMAX = (W15_CYC > W100_CYC) ? W15_CYC : W100_CYC;
  localparam int unsigned CW = $clog2(WMAX + 1);
  localparam logic [CW-1:0] LD15  = CW'(W15_CYC - 1);
  localparam logic [CW-1:0] LD100 = CW'(W100_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OFF, ST_PLL, ST_PREWAIT, ST_LOCKWAIT, ST_BANDWAIT, ST_DONE
  } st_t;

  st_t state;
  logic [BAND_W-1:0] band_in, band_q;
  logic [3:0] prediv_q;
  logic zero_rate_q;
  band_set_t tab;
  logic tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic accept;
  logic [CODE_W:0] code_sum;
  logic [CODE_W-1:0] code_sat;

  rate_band_sel u_band (.rate(req_rate), .band(band_in));
  band_table u_tab (.band(band_q), .set(tab));
  cycle_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  assign req_ready = (state == ST_IDLE);
  assign done = (state == ST_DONE);
  assign accept = req_valid && req_ready;

  assign tmr_load = (state == ST_PLL) ||
                    (tmr_zero && (state == ST_PREWAIT || state == ST_LOCKWAIT));
  assign tmr_val = (state == ST_PLL) ? LD15 : LD100;

  assign code_sum = {1'b0, phy_status[16:11]} + (CODE_W+1)'(tab.code_boost);
  assign code_sat = code_sum[CODE_W] ? CODE_MAX : code_sum[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      band_q <= '0;
      prediv_q <= '0;
      zero_rate_q <= 1'b0;
      dbg_ctrl <= '0;
      pll_cfg1 <= '0;
      pll_cfg2 <= '0;
      pll_cfg3 <= '0;
      ana_cfg1 <= '0;
      ana_cfg2 <= '0;
      ana_cfg3 <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          band_q <= band_in;
          prediv_q <= prediv_cur;
          zero_rate_q <= (req_rate == '0);
          dbg_ctrl <= {16'h0, 6'h0, req_hsync_low, req_vsync_low, 8'h0};
          state <= (req_rate == '0) ? ST_OFF : ST_PLL;
        end
        ST_OFF: begin
          ana_cfg1 <= LOWPWR_ANA1;
          pll_cfg1 <= '0;
          state <= ST_DONE;
        end
        ST_PLL: begin
          pll_cfg1 <= tab.pll1 & ~(32'h1 << 26);
          pll_cfg2 <= {tab.pll2[31:4], prediv_q};
          state <= ST_PREWAIT;
        end
        ST_PREWAIT: if (tmr_zero) begin
          pll_cfg3 <= PLL3_VAL;
          pll_cfg1 <= pll_cfg1 | (32'h1 << 25);
          state <= ST_LOCKWAIT;
        end
        ST_LOCKWAIT: if (tmr_zero) begin
          pll_cfg1 <= pll_cfg1 | 32'hC000_0000 | {26'h0, code_sat};
          state <= ST_BANDWAIT;
        end
        ST_BANDWAIT: if (tmr_zero) begin
          ana_cfg1 <= tab.ana1;
          ana_cfg2 <= tab.ana2 | (tab.use_cal ? {28'h0, cal_code[5:2]} : 32'h0);
          ana_cfg3 <= tab.ana3;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_lowpower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_rate == '0) |=> ##1 (ana_cfg1 == 32'h7 && pll_cfg1 == '0 && done));

  assert_clksel_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg1) |-> !pll_cfg1[26]);

  assert_enable_after_cfg3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_cfg1[25]) |-> (pll_cfg3 == 32'h1));

  assert_code_not_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_cfg1[31]) |-> (pll_cfg1[5:0] >= $past(phy_status[16:11])));

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/test_phy_rate_seq.sv
module test_phy_rate_seq;
  localparam int W15 = 7;
  localparam int W100 = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_rate = '0;
  logic req_hsync_low = 1'b0, req_vsync_low = 1'b0;
  logic [3:0] prediv_cur = '0;
  logic [5:0] cal_code = '0;
  logic [31:0] phy_status = '0;
  logic [31:0] dbg_ctrl, pll_cfg1, pll_cfg2, pll_cfg3, ana_cfg1, ana_cfg2, ana_cfg3;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  phy_rate_seq #(.W15_CYC(W15), .W100_CYC(W100)) i_phy_rate_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .req_hsync_low(req_hsync_low), .req_vsync_low(req_vsync_low),
    .prediv_cur(prediv_cur), .cal_code(cal_code), .phy_status(phy_status),
    .dbg_ctrl(dbg_ctrl), .pll_cfg1(pll_cfg1), .pll_cfg2(pll_cfg2), .pll_cfg3(pll_cfg3),
    .ana_cfg1(ana_cfg1), .ana_cfg2(ana_cfg2), .ana_cfg3(ana_cfg3), .done(done)
  );

  // R9 table, written out from the requirement
  function automatic logic [31:0] tval(int b, int f);
    logic [31:0] t [4][5] = '{
      '{32'h3ddc5040, 32'h8008430a, 32'h11ffff7f, 32'h80623000, 32'h0f80c285},
      '{32'h3ddc5040, 32'h80084343, 32'h11ffff7f, 32'h80623000, 32'h0f814385},
      '{32'h3ddc5040, 32'h80084381, 32'h01ffff7f, 32'h8063a800, 32'h0f81c485},
      '{32'h35dc5fc0, 32'h800863c0, 32'h01ffff7f, 32'h8063b000, 32'h0f8246b5}};
    return t[b][f];
  endfunction

  function automatic int band_of(longint r);
    int b = 0;
    if (r > 27000000) b++;
    if (r > 74250000) b++;
    if (r > 148500000) b++;
    return b;
  endfunction

  function automatic logic [5:0] trim(int b, logic [5:0] c);
    int v = int'(c) + ((b == 3) ? 2 : 0);
    return (v > 63) ? 6'd63 : 6'(v);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  logic [31:0] e_dbg, e_p1, e_p2, e_p3, e_a1, e_a2, e_a3;
  bit e_done, e_ready;
  int phase = 0, cnt = 0, m_band = 0;
  logic [3:0] m_pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_dbg = 0; e_p1 = 0; e_p2 = 0; e_p3 = 0; e_a1 = 0; e_a2 = 0; e_a3 = 0;
      phase = 0; cnt = 0;
    end else begin
      case (phase)
        0: if (req_valid) begin
          e_dbg = {16'h0, 6'h0, req_hsync_low, req_vsync_low, 8'h0};
          m_band = band_of(longint'(req_rate));
          m_pre = prediv_cur;
          phase = (req_rate == 0) ? 1 : 2;
        end
        1: begin e_a1 = 32'h7; e_p1 = 0; phase = 9; end
        2: begin
          e_p1 = tval(m_band, 0) & ~(32'h1 << 26);
          e_p2 = {tval(m_band, 1)[31:4], m_pre};
          cnt = W15; phase = 3;
        end
        3: begin cnt--; if (cnt == 0) begin e_p3 = 1; e_p1[25] = 1'b1; cnt = W100; phase = 4; end end
        4: begin
          cnt--;
          if (cnt == 0) begin
            e_p1 = e_p1 | 32'hC0000000 | {26'h0, trim(m_band, phy_status[16:11])};
            cnt = W100; phase = 5;
          end
        end
        5: begin
          cnt--;
          if (cnt == 0) begin
            e_a1 = tval(m_band, 2);
            e_a2 = tval(m_band, 3) | ((m_band < 2) ? {28'h0, cal_code[5:2]} : 32'h0);
            e_a3 = tval(m_band, 4);
            phase = 9;
          end
        end
        default: phase = 0;
      endcase
    end
    e_done = (phase == 9);
    e_ready = (phase == 0);
  end

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      chk("R1 ready", 32'(req_ready), 32'(e_ready));
      chk("R1 done", 32'(done), 32'(e_done));
      chk("R8 dbg_ctrl", dbg_ctrl, e_dbg);
      chk("R4/R5/R6 pll_cfg1", pll_cfg1, e_p1);
      chk("R4 pll_cfg2", pll_cfg2, e_p2);
      chk("R5 pll_cfg3", pll_cfg3, e_p3);
      chk("R7 ana_cfg1", ana_cfg1, e_a1);
      chk("R7 ana_cfg2", ana_cfg2, e_a2);
      chk("R7 ana_cfg3", ana_cfg3, e_a3);
    end
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(longint rate, bit h, bit v, logic [3:0] pre, logic [5:0] cal,
                     logic [5:0] code, bit hold_busy);
    while (!req_ready) @(negedge clk);
    req_rate = 32'(rate); req_hsync_low = h; req_vsync_low = v;
    prediv_cur = pre; cal_code = cal; phy_status = {15'h0, code, 11'h0};
    req_valid = 1'b1;
    @(negedge clk);
    if (hold_busy) begin
      req_rate = 32'd0; req_hsync_low = ~h; req_vsync_low = ~v; prediv_cur = ~pre;
      while (!done) @(negedge clk);
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
      while (!done) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic final_nonzero(string tag, int b, bit h, bit v, logic [3:0] pre,
                               logic [5:0] cal, logic [5:0] code);
    logic [31:0] p1;
    p1 = (tval(b, 0) & ~(32'h1 << 26)) | (32'h1 << 25) | 32'hC0000000 | {26'h0, trim(b, code)};
    chk({tag, " final pll_cfg1"}, pll_cfg1, p1);
    chk({tag, " final pll_cfg2"}, pll_cfg2, {tval(b, 1)[31:4], pre});
    chk({tag, " final ana_cfg2"}, ana_cfg2, tval(b, 3) | ((b < 2) ? {28'h0, cal[5:2]} : 32'h0));
    chk({tag, " final ana_cfg1"}, ana_cfg1, tval(b, 2));
    chk({tag, " final dbg_ctrl"}, dbg_ctrl, {16'h0, 6'h0, h, v, 8'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", 32'(req_ready), 32'd1);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 pll_cfg1", pll_cfg1, 32'h0);
    chk("R10 ana_cfg1", ana_cfg1, 32'h0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    run(25_000_000, 1, 0, 4'd5, 6'h2d, 6'd10, 0);
    final_nonzero("R3 R9 band0", 0, 1, 0, 4'd5, 6'h2d, 6'd10);
    run(27_000_000, 0, 0, 4'd0, 6'h3f, 6'd0, 0);
    final_nonzero("R3 boundary band0", 0, 0, 0, 4'd0, 6'h3f, 6'd0);
    run(27_000_001, 0, 1, 4'd9, 6'h13, 6'd33, 0);
    final_nonzero("R3 band1", 1, 0, 1, 4'd9, 6'h13, 6'd33);
    run(74_250_000, 1, 1, 4'd15, 6'h08, 6'd1, 0);
    final_nonzero("R3 boundary band1", 1, 1, 1, 4'd15, 6'h08, 6'd1);
    run(74_250_001, 0, 0, 4'd3, 6'h3c, 6'd40, 0);
    final_nonzero("R7 band2 no cal", 2, 0, 0, 4'd3, 6'h3c, 6'd40);
    run(148_500_000, 1, 0, 4'd7, 6'h21, 6'd17, 0);
    final_nonzero("R3 boundary band2", 2, 1, 0, 4'd7, 6'h21, 6'd17);
    run(148_500_001, 0, 1, 4'd2, 6'h3f, 6'd5, 0);
    final_nonzero("R6 band3 offset", 3, 0, 1, 4'd2, 6'h3f, 6'd5);
    run(297_000_000, 0, 0, 4'd1, 6'h0, 6'd62, 0);
    final_nonzero("R6 saturate 62", 3, 0, 0, 4'd1, 6'h0, 6'd62);
    run(297_000_000, 1, 1, 4'd1, 6'h0, 6'd63, 0);
    final_nonzero("R6 saturate 63", 3, 1, 1, 4'd1, 6'h0, 6'd63);

    // R2 low-power request: only ana_cfg1 and pll_cfg1 change
    run(0, 0, 1, 4'd0, 6'h0, 6'd0, 0);
    chk("R2 ana_cfg1", ana_cfg1, 32'h7);
    chk("R2 pll_cfg1", pll_cfg1, 32'h0);
    chk("R2 pll_cfg3 kept", pll_cfg3, 32'h1);
    chk("R2 ana_cfg3 kept", ana_cfg3, tval(3, 4));

    // R1 busy-time offers are ignored
    run(60_000_000, 1, 0, 4'd6, 6'h24, 6'd20, 1);
    final_nonzero("R1 busy offer ignored", 1, 1, 0, 4'd6, 6'h24, 6'd20);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule